// File: doc/BRIEF.md
# Masked Address Region Decoder

This block sorts incoming request addresses into address regions. Each request arrives with an address and an opaque payload under a valid/stall handshake. The block compares the address against a table of base/mask pairs, one pair per region, that is fixed at elaboration. It then produces a one-hot vector that names the chosen region. That vector carries one more bit than there are regions, and the extra top bit marks an address that lands in no region. A separate miss output repeats that top bit, so a neighbour can steer such requests to an error target without having to decode the vector.

The address and the payload travel next to the decode vector. A parameter picks one of two output stages. The first is a pure combinational path, where the result appears in the same cycle as the request. The second is a one-deep register stage, which delivers the result on the clock after acceptance and still accepts one request per clock. Both variants respect the downstream stall.

Top module: `region_decoder`

## Requirements
- R1: A request whose address satisfies (address AND mask k) == base k sets bit k of `out_hit`. Region k's base and mask sit at bits [k*ADDR_W +: ADDR_W] of `REGION_BASE` and `REGION_MASK`.
- R2: A request that matches no region sets bit NUM_REG of `out_hit` (all lower bits 0) and drives `out_miss` high. `out_miss` stays low for a mapped address.
- R3: When an address matches several regions, only the lowest-numbered match is reported, so `out_hit` has exactly one bit set whenever `out_valid` is high.
- R4: In registered mode the decode, address and payload of a request become visible, with `out_valid` high, in the cycle after the clock edge at which `in_valid` was high and `in_stall` low.
- R5: In registered mode, while `out_valid` and `out_stall` are both high, `in_stall` is high and `out_hit`, `out_addr` and `out_payload` hold their values into the next cycle.
- R6: In registered mode, `in_stall` is low whenever the stage is empty or `out_stall` is low. A new request is therefore accepted in the same cycle the held result is taken, and an unstalled stream moves one request per clock.
- R7: Reset (active-low, synchronous) clears `out_valid`. `out_hit` and `out_miss` read zero whenever `out_valid` is low.
- R8: In combinational mode `out_valid` equals `in_valid`, `in_stall` equals `out_stall`, and the decode, address and payload appear in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_stall | output | 1 | Request cannot be taken this cycle |
| in_addr | input | ADDR_W | Request address |
| in_payload | input | PAY_W | Sideband carried with the request |
| out_valid | output | 1 | Decoded result present |
| out_stall | input | 1 | Downstream cannot take the result |
| out_hit | output | NUM_REG+1 | One-hot region select; top bit means unmapped |
| out_miss | output | 1 | Result is for an unmapped address |
| out_addr | output | ADDR_W | Address of the result |
| out_payload | output | PAY_W | Payload of the result |

## Verification
In registered mode a result is due exactly one clock after its accepting edge. The bench drives each request on a falling edge and reads the outputs on the next falling edge, which is one register stage later. `in_stall` is combinational in both modes, so it is sampled a moment after the inputs change, before the following rising edge. In combinational mode every output is read in that same gap, with no edge in between. Hold behaviour is checked by keeping the downstream stall high across several falling edges and confirming that the result has not moved.

// File: rtl/region_decoder_pkg.sv
// Package: shared types for the region decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package region_decoder_pkg;

    // Output stage variant chosen at elaboration.
    typedef enum logic [0:0] {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_mode_e;

endpackage

// File: rtl/region_match.sv
// Module: region_match
// Compares one address against a table of base/mask pairs and returns a
// one-hot select of NUM_REG+1 bits. Bit NUM_REG is set when nothing matches.
// When several regions match, the lowest-numbered one wins.
// Assumes: each base has no bits outside its mask.
module region_match #(
    parameter int                      NUM_REG = 4,
    parameter int                      ADDR_W  = 32,
    parameter logic [NUM_REG*ADDR_W-1:0] REGION_BASE = '0,
    parameter logic [NUM_REG*ADDR_W-1:0] REGION_MASK = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_REG:0]   sel
);
    localparam int SEL_W = NUM_REG + 1;

    logic [NUM_REG-1:0] raw_hit;
    logic [NUM_REG-1:0] first_hit;

    // One comparator per region.
    for (genvar k = 0; k < NUM_REG; k++) begin : g_cmp
        assign raw_hit[k] =
            (addr & REGION_MASK[k*ADDR_W +: ADDR_W]) == REGION_BASE[k*ADDR_W +: ADDR_W];
    end

    // Keep only the lowest set bit so the result stays one-hot.
    always_comb begin
        first_hit = raw_hit & (~raw_hit + NUM_REG'(1));
    end

    // Append the unmapped flag as the top bit.
    always_comb begin
        sel = SEL_W'({~|raw_hit, first_hit});
    end

endmodule

// File: rtl/region_stage.sv
// Module: region_stage
// Output stage with a valid/stall handshake on both sides. MODE picks a
// plain wire-through or a one-deep register that refills in the cycle it
// drains, so an unstalled stream moves one item per clock.
// Assumes: up_data is stable while up_valid is held under stall.
module region_stage
    import region_decoder_pkg::*;
#(
    parameter int          W    = 8,
    parameter stage_mode_e MODE = STAGE_REG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_stall,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_stall,
    output logic [W-1:0] dn_data
);
    if (MODE == STAGE_REG) begin : g_reg
        logic         held_valid;
        logic [W-1:0] held_data;
        logic         take;

        // Stall upstream only when a held item cannot leave.
        always_comb begin
            up_stall = held_valid && dn_stall;
            take     = up_valid && !up_stall;
        end

        // Valid flag: reload whenever the slot is free or draining.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_valid <= 1'b0;
            end else if (!up_stall) begin
                held_valid <= up_valid;
            end
        end

        // Data slot: capture on acceptance only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_data <= '0;
            end else if (take) begin
                held_data <= up_data;
            end
        end

        assign dn_valid = held_valid;
        assign dn_data  = held_data;
    end else begin : g_comb
        // Straight path: handshake and data pass through untouched.
        always_comb begin
            up_stall = dn_stall;
            dn_valid = up_valid;
            dn_data  = up_data;
        end
    end

endmodule

// File: rtl/region_decoder.sv
// Module: region_decoder (top)
// Decodes a request address into a one-hot region select plus an
// unmapped flag, carrying address and payload alongside through a
// combinational or registered output stage.
// Assumes: bases lie inside their masks; overlaps resolve to lowest index.
module region_decoder
    import region_decoder_pkg::*;
#(
    parameter int          NUM_REG = 4,
    parameter int          ADDR_W  = 32,
    parameter int          PAY_W   = 16,
    parameter stage_mode_e MODE    = STAGE_REG,
    parameter logic [NUM_REG*ADDR_W-1:0] REGION_BASE = {
        32'h8000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
    parameter logic [NUM_REG*ADDR_W-1:0] REGION_MASK = {
        32'h8000_0000, 32'hE000_0000, 32'hF000_0000, 32'hF000_0000}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_stall,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [PAY_W-1:0]   in_payload,
    output logic               out_valid,
    input  logic               out_stall,
    output logic [NUM_REG:0]   out_hit,
    output logic               out_miss,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [PAY_W-1:0]   out_payload
);
    localparam int SEL_W = NUM_REG + 1;
    localparam int BUS_W = SEL_W + ADDR_W + PAY_W;

    logic [SEL_W-1:0] dec_sel;
    logic [BUS_W-1:0] stage_in;
    logic [BUS_W-1:0] stage_out;
    logic [SEL_W-1:0] stage_sel;
    logic             stage_valid;

    region_match #(
        .NUM_REG     (NUM_REG),
        .ADDR_W      (ADDR_W),
        .REGION_BASE (REGION_BASE),
        .REGION_MASK (REGION_MASK)
    ) u_match (
        .addr (in_addr),
        .sel  (dec_sel)
    );

    // Bundle select, address and payload for the stage.
    always_comb begin
        stage_in = {dec_sel, in_addr, in_payload};
    end

    region_stage #(
        .W    (BUS_W),
        .MODE (MODE)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_stall (in_stall),
        .up_data  (stage_in),
        .dn_valid (stage_valid),
        .dn_stall (out_stall),
        .dn_data  (stage_out)
    );

    // Unpack the stage output and blank the select while idle.
    always_comb begin
        stage_sel   = stage_out[BUS_W-1 -: SEL_W];
        out_addr    = stage_out[PAY_W +: ADDR_W];
        out_payload = stage_out[PAY_W-1:0];
        out_valid   = stage_valid;
        out_hit     = stage_valid ? stage_sel : '0;
        out_miss    = out_hit[NUM_REG];
    end

endmodule

// File: rtl/region_decoder_checker.sv
// Module: region_decoder_checker
// Protocol and decode properties for region_decoder, attached by bind.
// Assumes: same parameters as the bound instance.
module region_decoder_checker
    import region_decoder_pkg::*;
#(
    parameter int          NUM_REG = 4,
    parameter int          ADDR_W  = 32,
    parameter int          PAY_W   = 16,
    parameter stage_mode_e MODE    = STAGE_REG
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_stall,
    input logic [ADDR_W-1:0]  in_addr,
    input logic [PAY_W-1:0]   in_payload,
    input logic               out_valid,
    input logic               out_stall,
    input logic [NUM_REG:0]   out_hit,
    input logic               out_miss,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [PAY_W-1:0]   out_payload
);
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_hit) == 1)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_hit == '0 && !out_miss)); // R7

    AST_MISS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_hit[NUM_REG-1:0] == '0)); // R2

    if (MODE == STAGE_REG) begin : g_reg_props
        AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_stall) |=>
                (out_valid && out_addr == $past(in_addr)
                 && out_payload == $past(in_payload))); // R4

        AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_stall) |=>
                (out_valid && $stable(out_addr) && $stable(out_payload)
                 && $stable(out_hit))); // R5

        AST_FREE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_valid || !out_stall) |-> !in_stall); // R6
    end else begin : g_comb_props
        AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_stall == out_stall) && (out_valid == in_valid)
            && (out_addr == in_addr)); // R8
    end

endmodule

bind region_decoder region_decoder_checker #(
    .NUM_REG (NUM_REG),
    .ADDR_W  (ADDR_W),
    .PAY_W   (PAY_W),
    .MODE    (MODE)
) u_chk (.*);

// File: tb/region_decoder_test.sv
module region_decoder_test;
    import region_decoder_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Registered instance, default table.
    logic        in_valid = 1'b0, out_stall = 1'b0;
    logic [31:0] in_addr = '0;
    logic [15:0] in_payload = '0;
    logic        in_stall, out_valid, out_miss;
    logic [4:0]  out_hit;
    logic [31:0] out_addr;
    logic [15:0] out_payload;

    region_decoder #(.MODE(STAGE_REG)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stall(in_stall),
        .in_addr(in_addr), .in_payload(in_payload), .out_valid(out_valid),
        .out_stall(out_stall), .out_hit(out_hit), .out_miss(out_miss),
        .out_addr(out_addr), .out_payload(out_payload));

    // Combinational instance with overlapping regions.
    logic        c_in_valid = 1'b0, c_out_stall = 1'b0;
    logic [31:0] c_in_addr = '0;
    logic [15:0] c_in_payload = '0;
    logic        c_in_stall, c_out_valid, c_out_miss;
    logic [3:0]  c_out_hit;
    logic [31:0] c_out_addr;
    logic [15:0] c_out_payload;

    region_decoder #(
        .NUM_REG(3), .MODE(STAGE_COMB),
        .REGION_BASE({32'h5000_0000, 32'h0000_0000, 32'h4000_0000}),
        .REGION_MASK({32'hF000_0000, 32'h0000_0000, 32'hC000_0000})
    ) uut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_stall(c_in_stall),
        .in_addr(c_in_addr), .in_payload(c_in_payload), .out_valid(c_out_valid),
        .out_stall(c_out_stall), .out_hit(c_out_hit), .out_miss(c_out_miss),
        .out_addr(c_out_addr), .out_payload(c_out_payload));

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Check one registered result against expectations.
    task automatic check_out(input string req, input logic [4:0] hit,
                             input logic [31:0] a, input logic [15:0] p);
        check(req, "out_valid", 64'(out_valid), 64'd1);
        check(req, "out_hit", 64'(out_hit), 64'(hit));
        check(req, "out_miss", 64'(out_miss), 64'(hit[4]));
        check(req, "out_addr", 64'(out_addr), 64'(a));
        check(req, "out_payload", 64'(out_payload), 64'(p));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7", "reset valid", 64'(out_valid), 64'd0);
        check("R7", "reset hit", 64'(out_hit), 64'd0);
        check("R6", "reset in_stall", 64'(in_stall), 64'd0);
    endtask

    // One request, result one cycle later, then idle.
    task automatic t_single(input logic [31:0] a, input logic [15:0] p,
                            input logic [4:0] hit, input string req);
        in_valid = 1'b1; in_addr = a; in_payload = p;
        @(negedge clk);
        in_valid = 1'b0; in_addr = 32'hDEAD_BEEF;
        check_out(req, hit, a, p);
        @(negedge clk);
        check("R7", "idle valid", 64'(out_valid), 64'd0);
        check("R7", "idle hit", 64'(out_hit), 64'd0);
    endtask

    // Result held under stall; next request waits and then follows.
    task automatic t_backpressure();
        out_stall = 1'b1;
        in_valid = 1'b1; in_addr = 32'h1234_0000; in_payload = 16'hAAAA;
        @(negedge clk);
        check_out("R4", 5'b00010, 32'h1234_0000, 16'hAAAA);
        in_addr = 32'h4000_0004; in_payload = 16'hBBBB;
        #1;
        check("R5", "in_stall under hold", 64'(in_stall), 64'd1);
        @(negedge clk);
        @(negedge clk);
        check_out("R5", 5'b00010, 32'h1234_0000, 16'hAAAA);
        out_stall = 1'b0;
        #1;
        check("R6", "in_stall on drain", 64'(in_stall), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R6", 5'b10000, 32'h4000_0004, 16'hBBBB);
        @(negedge clk);
    endtask

    // Four back-to-back requests with no stall.
    task automatic t_stream();
        logic [31:0] addrs [4] = '{32'h0000_0010, 32'h3FFF_FFFC, 32'hF000_0000, 32'h7000_0000};
        logic [4:0]  hits  [4] = '{5'b00001, 5'b00100, 5'b01000, 5'b10000};
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_addr = addrs[i]; in_payload = 16'(i + 16'h100);
            #1;
            check("R6", "stream in_stall", 64'(in_stall), 64'd0);
            @(negedge clk);
            check_out("R6", hits[i], addrs[i], 16'(i + 16'h100));
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Combinational variant: same-cycle results and lowest-index priority.
    task automatic t_comb();
        c_in_valid = 1'b1; c_in_addr = 32'h5000_0010; c_in_payload = 16'h5A5A;
        c_out_stall = 1'b0;
        #1;
        check("R8", "comb valid", 64'(c_out_valid), 64'd1);
        check("R3", "overlap lowest", 64'(c_out_hit), 64'b0001);
        check("R8", "comb addr", 64'(c_out_addr), 64'h5000_0010);
        check("R8", "comb payload", 64'(c_out_payload), 64'h5A5A);
        check("R8", "comb in_stall", 64'(c_in_stall), 64'd0);
        c_in_addr = 32'h9000_0000;
        #1;
        check("R3", "catch-all region", 64'(c_out_hit), 64'b0010);
        check("R2", "comb no miss", 64'(c_out_miss), 64'd0);
        c_out_stall = 1'b1;
        #1;
        check("R8", "stall passthrough", 64'(c_in_stall), 64'd1);
        c_in_valid = 1'b0;
        #1;
        check("R8", "comb idle valid", 64'(c_out_valid), 64'd0);
        check("R7", "comb idle hit", 64'(c_out_hit), 64'd0);
        c_out_stall = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(32'h0ABC_0000, 16'h0001, 5'b00001, "R1");
        t_single(32'h1FFF_FFFF, 16'h0002, 5'b00010, "R1");
        t_single(32'h3000_0000, 16'h0003, 5'b00100, "R4");
        t_single(32'hC000_1234, 16'h0004, 5'b01000, "R1");
        t_single(32'h4000_0000, 16'h0005, 5'b10000, "R2");
        t_backpressure();
        t_stream();
        t_comb();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule